// File: doc/BRIEF.md
# Bidirectional Sampling Pulse Sequencer

This block is the digital timing core of a column driver. A single token walks through a chain of group stages. Each group owns three adjacent output channels, and the block raises a sampling strobe on a channel when the token sits on its group and the matching phase enable fires. The three phase clocks are modelled as clock enables (`ph_en`) inside one synchronous clock domain. The number of groups is a parameter; by default there are 160 groups and 480 strobes.

A scan can run either way along the chain. In right shift the scan starts on `start_r_in`, runs from channel 0 upward and hands off on `carry_l_out`. In left shift the scan starts on `start_l_in`, runs from the top channel downward and hands off on `carry_r_out`. This lets several devices be chained in either direction.

Sampling is either sequential, with one colour per phase, or simultaneous, with all three colours on phase 1. The block also registers the select that decides which of two sample-hold banks is sampling and which is driving the outputs.

Top module: `sps_sequencer`

## Requirements
- R1: While `rst` is high, the block clears the chain at each clock edge. From the next edge on, every strobe and both carry outputs read low.
- R2: The block captures a low-to-high change of the active start input at a clock edge while no scan is running. This loads the first group of the scan, and the first strobe rises at the edge that samples a phase enable after that load.
- R3: With `dir_right`=1, the active start input is `start_r_in`. Group g owns strobe bits 3g, 3g+1 and 3g+2 (bit 0 is channel 1), and groups are visited from 0 upward.
- R4: With `dir_right`=0, the active start input is `start_l_in`, and groups are visited from the top group down to group 0.
- R5: In sequential mode with right shift, `ph_en[k]` fires strobe bit 3g+k of the current group g.
- R6: In sequential mode with left shift, `ph_en[0]` fires bit 3g+2, `ph_en[1]` fires bit 3g+1 and `ph_en[2]` fires bit 3g.
- R7: With `simul_mode`=1, `ph_en[0]` fires all three strobes of the group and moves the token on, and `ph_en[1]` and `ph_en[2]` have no effect.
- R8: A `simul_mode` value that is not a clean 1 (undriven or unknown) selects sequential mode.
- R9: A start input that stays high does not start a second scan, and start changes during a scan are ignored. Only one new low-to-high change after the scan restarts it.
- R10: After the enable that ends the last group, the output pin on the far side (`carry_l_out` for right shift, `carry_r_out` for left) is high for exactly one clock. The other carry output stays low.
- R11: `bank1_sample` equals `bank_sel` delayed by one clock, and `bank2_sample` is its complement. This holds in reset as well.
- R12: Changes to `dir_right` and `simul_mode` made during a scan take effect only after the scan ends.
- R13: Each strobe is high for exactly one clock per firing enable. The token moves only on the last phase of a group (`ph_en[2]` in sequential mode, `ph_en[0]` in simultaneous mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_right | input | 1 | 1 = right shift, 0 = left shift |
| simul_mode | input | 1 | 1 = simultaneous sampling, else sequential |
| ph_en | input | 3 | Phase enables for phases 1..3 (bit 0 = phase 1) |
| start_r_in | input | 1 | Right-side cascade start input |
| start_l_in | input | 1 | Left-side cascade start input |
| carry_r_out | output | 1 | Right-side cascade output (left shift) |
| carry_l_out | output | 1 | Left-side cascade output (right shift) |
| bank_sel | input | 1 | Sample-hold bank select |
| bank1_sample | output | 1 | Bank 1 is sampling (bank 2 drives outputs) |
| bank2_sample | output | 1 | Bank 2 is sampling (bank 1 drives outputs) |
| strobe | output | 3*N_GROUPS | Sampling strobes, bit 0 = channel 1 |

## Verification
The assertions check several properties on every cycle:
- the token is never in more than one group, and it stays put unless the last phase enable fires;
- no more than three strobes are high at once, and the strobes clear after reset;
- the two carry outputs are never high together;
- the bank outputs track the select one clock late;
- the latched direction and mode cannot change during a scan.

Some behaviours can only be shown by the bench's scenarios, which compare every strobe against a reference model:
- the exact channel order in each direction;
- the phase-to-colour swap between right and left shift;
- the carry timing;
- that a held or repeated start does not retrigger;
- that direction or mode changes made mid-scan are deferred to the next scan.

// File: rtl/sps_pkg.sv
package sps_pkg;

  localparam int unsigned COLOURS = 3;

  typedef struct packed {
    logic dir_right;
    logic simul;
  } scan_cfg_t;

  // Colour slot fired by phase k in sequential mode for a given direction.
  function automatic int unsigned seq_slot(input int unsigned k, input logic dir_right);
    return dir_right ? k : (COLOURS - 1 - k);
  endfunction

endpackage

// File: rtl/sps_start_ctl.sv
module sps_start_ctl
  import sps_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      dir_in,
  input  logic      mode_in,
  input  logic      start_r,
  input  logic      start_l,
  input  logic      busy,
  output scan_cfg_t cfg,
  output logic      trig
);

  scan_cfg_t cfg_q;
  logic      prev_q;
  logic      act;

  always_comb begin
    if (busy) begin
      cfg = cfg_q;
    end else begin
      cfg.dir_right = dir_in;
      cfg.simul     = (mode_in === 1'b1);
    end
    act  = cfg.dir_right ? start_r : start_l;
    trig = act & ~prev_q & ~busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cfg_q  <= cfg;
      prev_q <= act;
    end
  end

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cfg == $past(cfg)));

  // R9
  no_trig_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !trig);

endmodule

// File: rtl/sps_token_chain.sv
module sps_token_chain
  import sps_pkg::*;
#(
  parameter int unsigned N_GROUPS = 160
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig,
  input  scan_cfg_t           cfg,
  input  logic [2:0]          ph_en,
  output logic [N_GROUPS-1:0] token,
  output logic                busy,
  output logic                last_adv
);

  localparam logic [N_GROUPS-1:0] FIRST_LO = N_GROUPS'(1);
  localparam logic [N_GROUPS-1:0] FIRST_HI = FIRST_LO << (N_GROUPS - 1);

  logic [N_GROUPS-1:0] token_q;
  logic                adv;
  logic                at_end;

  always_comb begin
    adv      = cfg.simul ? ph_en[0] : ph_en[COLOURS-1];
    at_end   = cfg.dir_right ? token_q[N_GROUPS-1] : token_q[0];
    busy     = |token_q;
    last_adv = busy & adv & at_end;
    token    = token_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      token_q <= '0;
    end else if (trig) begin
      token_q <= cfg.dir_right ? FIRST_LO : FIRST_HI;
    end else if (busy && adv) begin
      token_q <= cfg.dir_right ? (token_q << 1) : (token_q >> 1);
    end
  end

  // R3
  token_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(token_q));

  // R13
  token_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !adv) |=> $stable(token_q));

endmodule

// File: rtl/sps_strobe_decode.sv
module sps_strobe_decode
  import sps_pkg::*;
#(
  parameter int unsigned N_GROUPS = 160
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_GROUPS-1:0]         token,
  input  scan_cfg_t                   cfg,
  input  logic [2:0]                  ph_en,
  output logic [COLOURS*N_GROUPS-1:0] strobe
);

  localparam int unsigned N_CH = COLOURS * N_GROUPS;

  logic [COLOURS-1:0] fire;
  logic [N_CH-1:0]    strobe_d;
  logic [N_CH-1:0]    strobe_q;

  // Per-slot fire condition shared by all groups.
  always_comb begin
    fire = '0;
    for (int unsigned k = 0; k < COLOURS; k++) begin
      if (cfg.simul) begin
        fire[k] = ph_en[0];
      end else begin
        fire[seq_slot(k, cfg.dir_right)] = ph_en[k];
      end
    end
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    for (genvar c = 0; c < COLOURS; c++) begin : g_col
      assign strobe_d[COLOURS*g + c] = token[g] & fire[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= '0;
    else     strobe_q <= strobe_d;
  end

  assign strobe = strobe_q;

  // R7
  strobe_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe_q) <= COLOURS);

  // R1
  strobe_reset_chk: assert property (@(posedge clk)
    rst |=> (strobe_q == '0));

  // R13
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (token == '0) |=> (strobe_q == '0));

endmodule

// File: rtl/sps_sequencer.sv
module sps_sequencer
  import sps_pkg::*;
#(
  parameter int unsigned N_GROUPS = 160
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        dir_right,
  input  logic                        simul_mode,
  input  logic [2:0]                  ph_en,
  input  logic                        start_r_in,
  input  logic                        start_l_in,
  output logic                        carry_r_out,
  output logic                        carry_l_out,
  input  logic                        bank_sel,
  output logic                        bank1_sample,
  output logic                        bank2_sample,
  output logic [COLOURS*N_GROUPS-1:0] strobe
);

  scan_cfg_t           cfg;
  logic                trig;
  logic                busy;
  logic                last_adv;
  logic [N_GROUPS-1:0] token;
  logic                carry_r_q, carry_l_q;
  logic                bank1_q, bank2_q;

  sps_start_ctl i_start (
    .clk     (clk),
    .rst     (rst),
    .dir_in  (dir_right),
    .mode_in (simul_mode),
    .start_r (start_r_in),
    .start_l (start_l_in),
    .busy    (busy),
    .cfg     (cfg),
    .trig    (trig)
  );

  sps_token_chain #(.N_GROUPS(N_GROUPS)) i_chain (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .cfg      (cfg),
    .ph_en    (ph_en),
    .token    (token),
    .busy     (busy),
    .last_adv (last_adv)
  );

  sps_strobe_decode #(.N_GROUPS(N_GROUPS)) i_decode (
    .clk    (clk),
    .rst    (rst),
    .token  (token),
    .cfg    (cfg),
    .ph_en  (ph_en),
    .strobe (strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_r_q <= 1'b0;
      carry_l_q <= 1'b0;
    end else begin
      carry_l_q <= last_adv & cfg.dir_right;
      carry_r_q <= last_adv & ~cfg.dir_right;
    end
  end

  // Bank select is not reset: it follows its input at all times.
  always_ff @(posedge clk) begin
    bank1_q <= bank_sel;
    bank2_q <= ~bank_sel;
  end

  assign carry_r_out  = carry_r_q;
  assign carry_l_out  = carry_l_q;
  assign bank1_sample = bank1_q;
  assign bank2_sample = bank2_q;

  // R10
  carry_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(carry_r_q && carry_l_q));

  // R10
  carry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_r_q || carry_l_q) |=> !(carry_r_q || carry_l_q));

  // R11
  bank_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bank1_q == $past(bank_sel)) && (bank2_q != bank1_q));

endmodule

// File: tb/test_sps_sequencer.sv
module test_sps_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 160;
  localparam int NC = 3 * NG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_right = 1'b1;
  logic          simul_mode = 1'b0;
  logic [2:0]    ph_en = '0;
  logic          start_r_in = 1'b0, start_l_in = 1'b0;
  logic          bank_sel = 1'b0;
  wire           carry_r_out, carry_l_out, bank1_sample, bank2_sample;
  wire  [NC-1:0] strobe;

  sps_sequencer #(.N_GROUPS(NG)) i_sps_sequencer (
    .clk, .rst, .dir_right, .simul_mode, .ph_en, .start_r_in, .start_l_in,
    .carry_r_out, .carry_l_out, .bank_sel, .bank1_sample, .bank2_sample, .strobe
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  string tag = "R1";

  // Reference model state
  bit          m_busy = 0, m_prev = 0, m_dir = 0, m_mode = 0;
  int          m_pos = 0;
  bit [NC-1:0] e_strobe = '0;
  bit          e_cl = 0, e_cr = 0, e_b1 = 0;

  task automatic model_edge();
    bit ed, em, act, trig, adv;
    e_b1 = bank_sel;
    if (rst) begin
      m_busy = 0; m_prev = 0; e_strobe = '0; e_cl = 0; e_cr = 0;
      return;
    end
    ed   = m_busy ? m_dir : dir_right;
    em   = m_busy ? m_mode : (simul_mode === 1'b1);
    act  = ed ? start_r_in : start_l_in;
    trig = !m_busy && act && !m_prev;
    m_prev = act;
    e_strobe = '0; e_cl = 0; e_cr = 0;
    if (m_busy) begin
      if (em) begin
        if (ph_en[0]) for (int c = 0; c < 3; c++) e_strobe[3*m_pos + c] = 1'b1;
        adv = ph_en[0];
      end else begin
        for (int k = 0; k < 3; k++)
          if (ph_en[k]) e_strobe[3*m_pos + (ed ? k : 2 - k)] = 1'b1;
        adv = ph_en[2];
      end
      if (adv) begin
        if (ed && m_pos == NG - 1) begin m_busy = 0; e_cl = 1; end
        else if (!ed && m_pos == 0) begin m_busy = 0; e_cr = 1; end
        else m_pos = ed ? m_pos + 1 : m_pos - 1;
      end
    end
    if (trig) begin
      m_busy = 1; m_pos = ed ? 0 : NG - 1; m_dir = ed; m_mode = em;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_checks++;
    if (strobe !== e_strobe) begin
      n_fail++;
      $display("FAIL %s strobe: actual %0d high (first mismatch diff %h) expected %0d high",
               tag, $countones(strobe), strobe ^ e_strobe, $countones(e_strobe));
    end
    n_checks++;
    if (carry_l_out !== e_cl || carry_r_out !== e_cr) begin
      n_fail++;
      $display("FAIL R10 carry: actual l=%b r=%b expected l=%b r=%b",
               carry_l_out, carry_r_out, e_cl, e_cr);
    end
    n_checks++;
    if (bank1_sample !== e_b1 || bank2_sample !== !e_b1) begin
      n_fail++;
      $display("FAIL R11 bank: actual %b%b expected %b%b",
               bank1_sample, bank2_sample, e_b1, !e_b1);
    end
  endtask

  task automatic pulse_start(input bit right);
    if (right) start_r_in = 1; else start_l_in = 1;
    step();
    start_r_in = 0; start_l_in = 0;
  endtask

  // Rotating phases through a full scan plus margin.
  task automatic scan_rotate(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      ph_en = 3'b001 << (i % 3);
      bank_sel = $urandom_range(0, 1);
      step();
    end
    ph_en = '0;
  endtask

  task automatic scan_random(input int cycles, input bit hold_start);
    for (int i = 0; i < cycles; i++) begin
      ph_en = 3'($urandom_range(0, 7));
      bank_sel = $urandom_range(0, 1);
      if (hold_start) begin start_r_in = 1; start_l_in = 1; end
      step();
    end
    ph_en = '0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, bank follows even in reset
    tag = "R1";
    for (int i = 0; i < 4; i++) begin bank_sel = i[0]; ph_en = 3'b111; start_r_in = i[0]; step(); end
    start_r_in = 0; ph_en = '0; rst = 0;
    step();

    // R2 R3 R5: right shift sequential
    tag = "R2 R3 R5";
    dir_right = 1; simul_mode = 0;
    pulse_start(1);
    scan_rotate(3 * NG + 6);

    // R4 R6: left shift sequential, right-side start ignored
    tag = "R4 R6";
    dir_right = 0;
    start_r_in = 1; step(); start_r_in = 0;
    pulse_start(0);
    scan_rotate(3 * NG + 6);

    // R7: simultaneous, phases 2 and 3 random noise
    tag = "R7";
    dir_right = 1; simul_mode = 1;
    pulse_start(1);
    for (int i = 0; i < NG + 8; i++) begin
      ph_en = {2'($urandom_range(0, 3)), 1'b1};
      step();
    end
    ph_en = 3'b110; step(); step();

    // R8: undriven mode means sequential
    tag = "R8";
    simul_mode = 1'bz; dir_right = 0;
    pulse_start(0);
    scan_rotate(3 * NG + 6);
    simul_mode = 0;

    // R9: start held high across and after a scan
    tag = "R9";
    dir_right = 1;
    scan_random(3 * NG * 2 + 200, 1);
    start_r_in = 0; start_l_in = 0;
    scan_random(600, 0);

    // R12: flip direction and mode mid-scan
    tag = "R12";
    dir_right = 1; simul_mode = 0;
    pulse_start(1);
    scan_rotate(30);
    dir_right = 0; simul_mode = 1;
    scan_rotate(3 * NG);
    pulse_start(0);
    for (int i = 0; i < NG + 4; i++) begin ph_en = 3'b001; step(); end
    ph_en = '0;

    // R13: sparse phases, long gaps
    tag = "R13";
    dir_right = 0; simul_mode = 0;
    pulse_start(0);
    for (int i = 0; i < 2500; i++) begin
      ph_en = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      step();
    end

    // Random mix, then a mid-run reset (R1)
    tag = "R2 R9";
    for (int i = 0; i < 6000; i++) begin
      dir_right  = ($urandom_range(0, 15) == 0) ? !dir_right : dir_right;
      simul_mode = ($urandom_range(0, 15) == 0) ? 1'($urandom_range(0, 1)) : simul_mode;
      start_r_in = ($urandom_range(0, 40) == 0);
      start_l_in = ($urandom_range(0, 40) == 0);
      ph_en      = 3'($urandom_range(0, 7));
      bank_sel   = $urandom_range(0, 1);
      step();
    end
    tag = "R1";
    rst = 1; step(); step(); rst = 0; step();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule